// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Controller

This block is a synchronous controller that sits between a simple request port and a 16-bit-wide extended-data-output DRAM with a multiplexed 9-bit address bus. Each request carries an 18-bit word address, a read/write flag, 16 bits of write data and two byte enables. The controller turns each accepted request into a row open, a column strobe sequence and, for reads, a one-cycle response carrying the read word. The upper nine address bits select the row and the lower nine select the column. The low byte lane is strobed by its own column strobe and the high byte lane by a second one, so byte writes and byte reads need no read-modify-write.

After an access the row stays open. A following request to the same row is served with column strobes alone. A request to another row, or a refresh request from an external arbiter, closes the row by raising the row strobe. The row strobe then stays high for the precharge count before any row opens again. Writes are early writes: write enable and the write data are set up one cycle before the column strobes fall. Reads rely on extended data output. The word is sampled after the column strobes rise again, while the row strobe and output enable are still low. All timing is set by cycle-count parameters.

The state machine has seven states:
- PRECHARGE: row strobe high, timed by T_RP. This is the state after reset.
- IDLE: no row open, ready for a request.
- ROW: row address driven with the row strobe low, timed by T_RCD.
- SETUP: column address, write enable and write data driven for one cycle.
- STROBE: column strobes low, timed by T_CAS.
- HOLD: column strobes high with the output still enabled, timed by T_CP. The read sample is taken at the end of this state.
- OPEN: row held open, ready for a request.

The transitions are:
- PRECHARGE→IDLE when the timer expires and nothing is pending.
- PRECHARGE→ROW when the timer expires and a miss request is pending.
- IDLE→ROW when a request is accepted.
- ROW→SETUP when the timer expires.
- SETUP→STROBE after one cycle.
- STROBE→HOLD when the timer expires.
- HOLD→OPEN when the timer expires.
- OPEN→SETUP on an accepted request to the same row.
- OPEN→PRECHARGE on an accepted request to another row, which becomes pending.
- OPEN→PRECHARGE on a refresh request.

Top module: `edo_ctrl`

## Requirements
- R1: During and after reset the row strobe and both column strobes are high, the data bus driver is off, no response is signalled, and the request port is not ready until the row strobe has been high for T_RP cycles.
- R2: On the cycle the row strobe falls, the memory address bus carries request address bits [17:9]. On the cycle the column strobes fall, it carries bits [8:0].
- R3: Byte enable bit 0 selects the low lane (data bits [7:0]) and its strobe; bit 1 selects the high lane (bits [15:8]) and its strobe. Only the strobes of enabled lanes fall, so a write changes only enabled lanes.
- R4: For a write, write enable is low and the data driver is on with the request data in the cycle before the column strobes fall and while they are low.
- R5: For a read, write enable stays high and output enable is low. The word on the memory data input is sampled at the end of the strobe-high hold phase. The response valid is a one-cycle pulse, with disabled lanes returned as zero.
- R6: A request whose row equals the open row is served without a row strobe transition.
- R7: A request to a row other than the open one raises the row strobe. The strobe stays high for at least T_RP cycles before it falls for the new row.
- R8: While the refresh request is high, the port is not ready. If a row is open, the row strobe rises and remains high.
- R9: The column strobes fall no earlier than T_RCD+1 cycles after the row strobe falls, stay low for exactly T_CAS cycles, and are never low while the row strobe is high.
- R10: A request is taken on a clock edge where valid and ready are both high. Ready stays low from then until the access has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address, row in [17:9], column in [8:0] |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte lane enables, bit 0 low lane |
| refresh_req | input | 1 | Close the open row and hold it closed |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 9 | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_lcas_n | output | 1 | Low-lane column strobe, active low |
| mem_ucas_n | output | 1 | High-lane column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 16 | Data to the memory |
| mem_dq_in | input | 16 | Data from the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |

## Verification
The bench builds the controller with T_RP=3, T_RCD=2, T_CAS=2 and T_CP=1. Row-to-column and strobe-low phases therefore last more than one cycle, which exercises the timer reloads and the exact strobe-width and precharge checks that a one-cycle setting would hide. A behavioural memory model with a sparse array stores and returns data by byte lane. It also counts row openings, so page hits and misses can be told apart at the pins.

// File: rtl/edo_ctrl_pkg.sv
package edo_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_PRECHARGE,
        ST_IDLE,
        ST_ROW,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_OPEN
    } ctrl_state_t;

    function automatic int max_of2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edo_ctrl_timer.sv
module edo_ctrl_timer #(
    parameter int CNT_W   = 2,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CNT_W'(RST_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/edo_ctrl_page.sv
module edo_ctrl_page #(
    parameter int ROW_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_set,
    input  logic             close,
    input  logic [ROW_W-1:0] row_in,
    input  logic [ROW_W-1:0] cmp_row,
    output logic             hit
);
    logic [ROW_W-1:0] open_row;
    logic             open_vld;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_vld <= 1'b0;
            open_row <= '0;
        end else if (close) begin
            open_vld <= 1'b0;
        end else if (open_set) begin
            open_vld <= 1'b1;
            open_row <= row_in;
        end
    end

    assign hit = open_vld && (open_row == cmp_row);
endmodule

// File: rtl/edo_ctrl_rdcap.sv
module edo_ctrl_rdcap #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [1:0]        lane_en,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int LANE_W = DATA_W / 2;

    logic [DATA_W-1:0] masked;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign masked[g*LANE_W +: LANE_W] =
            lane_en[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) begin
                rsp_data <= masked;
            end
        end
    end

    assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/edo_ctrl.sv
module edo_ctrl
    import edo_ctrl_pkg::*;
#(
    parameter int ROW_W  = 9,
    parameter int COL_W  = 9,
    parameter int DATA_W = 16,
    parameter int T_RP   = 3,
    parameter int T_RCD  = 1,
    parameter int T_CAS  = 1,
    parameter int T_CP   = 1,
    localparam int ADDR_W = ROW_W + COL_W,
    localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    input  logic              refresh_req,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [MA_W-1:0]   mem_addr,
    output logic              mem_ras_n,
    output logic              mem_lcas_n,
    output logic              mem_ucas_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    localparam int T_MAX = max_of2(max_of2(T_RP, T_RCD), max_of2(T_CAS, T_CP));
    localparam int CNT_W = (T_MAX > 1) ? $clog2(T_MAX) : 1;
    localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] RCD_LD = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] CAS_LD = CNT_W'(T_CAS - 1);
    localparam logic [CNT_W-1:0] CP_LD  = CNT_W'(T_CP - 1);

    ctrl_state_t state, state_nx;

    logic              accept;
    logic              tmr_load, tmr_done;
    logic [CNT_W-1:0]  tmr_val;
    logic              page_set, page_close, page_hit;
    logic              capture;
    logic              pend_set, pend_clr, pending;
    logic [ROW_W-1:0]  page_row_in;

    logic              cur_write;
    logic [ROW_W-1:0]  cur_row;
    logic [COL_W-1:0]  cur_col;
    logic [DATA_W-1:0] cur_wdata;
    logic [1:0]        cur_be;

    logic [ROW_W-1:0]  req_row;
    logic [COL_W-1:0]  req_col;

    assign req_row = req_addr[ADDR_W-1:COL_W];
    assign req_col = req_addr[COL_W-1:0];

    assign req_ready = ((state == ST_IDLE) || (state == ST_OPEN)) && !refresh_req;
    assign accept    = req_valid && req_ready;

    edo_ctrl_timer #(.CNT_W(CNT_W), .RST_VAL(T_RP - 1)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    assign page_row_in = (state == ST_IDLE) ? req_row : cur_row;

    edo_ctrl_page #(.ROW_W(ROW_W)) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_set (page_set),
        .close    (page_close),
        .row_in   (page_row_in),
        .cmp_row  (req_row),
        .hit      (page_hit)
    );

    edo_ctrl_rdcap #(.DATA_W(DATA_W)) u_rdcap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .lane_en   (cur_be),
        .dq_in     (mem_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_rdata)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_PRECHARGE;
        end else begin
            state <= state_nx;
        end
    end

    // Request latch and pending-miss flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_write <= 1'b0;
            cur_row   <= '0;
            cur_col   <= '0;
            cur_wdata <= '0;
            cur_be    <= '0;
            pending   <= 1'b0;
        end else begin
            if (accept) begin
                cur_write <= req_write;
                cur_row   <= req_row;
                cur_col   <= req_col;
                cur_wdata <= req_wdata;
                cur_be    <= req_be;
            end
            if (pend_set) begin
                pending <= 1'b1;
            end else if (pend_clr) begin
                pending <= 1'b0;
            end
        end
    end

    // Next state and control strobes
    always_comb begin
        state_nx   = state;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        page_set   = 1'b0;
        page_close = 1'b0;
        capture    = 1'b0;
        pend_set   = 1'b0;
        pend_clr   = 1'b0;
        unique case (state)
            ST_PRECHARGE: begin
                if (tmr_done) begin
                    if (pending) begin
                        state_nx = ST_ROW;
                        tmr_load = 1'b1;
                        tmr_val  = RCD_LD;
                        page_set = 1'b1;
                        pend_clr = 1'b1;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end
            end
            ST_IDLE: begin
                if (accept) begin
                    state_nx = ST_ROW;
                    tmr_load = 1'b1;
                    tmr_val  = RCD_LD;
                    page_set = 1'b1;
                end
            end
            ST_ROW: begin
                if (tmr_done) begin
                    state_nx = ST_SETUP;
                end
            end
            ST_SETUP: begin
                state_nx = ST_STROBE;
                tmr_load = 1'b1;
                tmr_val  = CAS_LD;
            end
            ST_STROBE: begin
                if (tmr_done) begin
                    state_nx = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = CP_LD;
                end
            end
            ST_HOLD: begin
                if (tmr_done) begin
                    state_nx = ST_OPEN;
                    capture  = !cur_write;
                end
            end
            ST_OPEN: begin
                if (refresh_req) begin
                    state_nx   = ST_PRECHARGE;
                    tmr_load   = 1'b1;
                    tmr_val    = RP_LD;
                    page_close = 1'b1;
                end else if (accept) begin
                    if (page_hit) begin
                        state_nx = ST_SETUP;
                    end else begin
                        state_nx   = ST_PRECHARGE;
                        tmr_load   = 1'b1;
                        tmr_val    = RP_LD;
                        page_close = 1'b1;
                        pend_set   = 1'b1;
                    end
                end
            end
            default: begin
                state_nx = ST_PRECHARGE;
            end
        endcase
    end

    // Memory-side outputs
    always_comb begin
        mem_ras_n  = 1'b1;
        mem_lcas_n = 1'b1;
        mem_ucas_n = 1'b1;
        mem_we_n   = 1'b1;
        mem_oe_n   = 1'b1;
        mem_dq_oe  = 1'b0;
        mem_addr   = '0;
        mem_dq_out = cur_wdata;
        unique case (state)
            ST_PRECHARGE, ST_IDLE: begin
                mem_addr = '0;
            end
            ST_ROW: begin
                mem_ras_n = 1'b0;
                mem_addr  = MA_W'(cur_row);
            end
            ST_SETUP: begin
                mem_ras_n = 1'b0;
                mem_addr  = MA_W'(cur_col);
                mem_we_n  = !cur_write;
                mem_dq_oe = cur_write;
                mem_oe_n  = cur_write;
            end
            ST_STROBE: begin
                mem_ras_n  = 1'b0;
                mem_addr   = MA_W'(cur_col);
                mem_lcas_n = !cur_be[0];
                mem_ucas_n = !cur_be[1];
                mem_we_n   = !cur_write;
                mem_dq_oe  = cur_write;
                mem_oe_n   = cur_write;
            end
            ST_HOLD: begin
                mem_ras_n = 1'b0;
                mem_addr  = MA_W'(cur_col);
                mem_oe_n  = cur_write;
            end
            ST_OPEN: begin
                mem_ras_n = 1'b0;
                mem_addr  = MA_W'(cur_col);
            end
            default: begin
                mem_ras_n = 1'b1;
            end
        endcase
    end

    // Checker state: consecutive cycles with the row strobe high
    logic [CNT_W:0] ras_hi_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_hi_cnt <= '0;
        end else if (!mem_ras_n) begin
            ras_hi_cnt <= '0;
        end else if (ras_hi_cnt < (CNT_W+1)'(T_RP)) begin
            ras_hi_cnt <= ras_hi_cnt + 1'b1;
        end
    end

    assert_standby_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ras_n |-> (!mem_dq_oe && mem_lcas_n && mem_ucas_n));

    assert_precharge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ras_n) |-> (ras_hi_cnt >= (CNT_W+1)'(T_RP)));

    assert_cas_in_row_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_lcas_n || !mem_ucas_n) |-> !mem_ras_n);

    assert_we_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((!mem_lcas_n || !mem_ucas_n) && $past(mem_lcas_n && mem_ucas_n) && !mem_we_n)
        |-> $past(!mem_we_n && mem_dq_oe));

    assert_oe_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> mem_we_n);

    assert_refresh_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_req && state == ST_OPEN) |=> mem_ras_n);

    assert_ready_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_lcas_n && mem_ucas_n && !mem_dq_oe));

    assert_hit_keeps_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN && accept && page_hit) |=> !mem_ras_n);
endmodule

// File: tb/edo_ctrl_bench.sv
module edo_ctrl_bench;
    localparam int P_RP  = 3;
    localparam int P_RCD = 2;
    localparam int P_CAS = 2;
    localparam int P_CP  = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        refresh_req = 1'b0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [8:0]  mem_addr;
    logic        mem_ras_n, mem_lcas_n, mem_ucas_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [15:0] mem_dq_out, mem_dq_in;

    always #10 clk = ~clk;

    edo_ctrl #(.T_RP(P_RP), .T_RCD(P_RCD), .T_CAS(P_CAS), .T_CP(P_CP)) u_edo_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .refresh_req(refresh_req), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_ras_n(mem_ras_n),
        .mem_lcas_n(mem_lcas_n), .mem_ucas_n(mem_ucas_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_oe(mem_dq_oe)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [15:0] mdl_mem [int];
    logic        p_ras = 1, p_l = 1, p_u = 1, p_we = 1, p_dqoe = 0;
    int          ras_hi_run = 0, since_ras = 0, l_low = 0, u_low = 0;
    int          ras_falls = 0;
    logic [8:0]  m_row = '0, m_col = '0;
    logic [1:0]  m_lanes = '0;
    logic [15:0] rd_q = '0;

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    always @(posedge clk) begin
        if (rst_n) begin
            int key;
            logic [15:0] old;
            logic fl, fu;
            if (p_ras && !mem_ras_n) begin
                chk(ras_hi_run >= P_RP, "R7 precharge", ras_hi_run, P_RP);
                ras_falls++;
                m_row = mem_addr;
                since_ras = 1;
            end else if (!mem_ras_n) begin
                since_ras++;
            end
            if (mem_ras_n) ras_hi_run++; else ras_hi_run = 0;
            fl = p_l && !mem_lcas_n;
            fu = p_u && !mem_ucas_n;
            if (fl || fu) begin
                chk(since_ras >= P_RCD + 2, "R9 ras-to-cas", since_ras, P_RCD + 2);
                m_col = mem_addr;
                m_lanes = {!mem_ucas_n, !mem_lcas_n};
                key = int'({m_row, m_col});
                if (!mem_we_n) begin
                    chk(!p_we && p_dqoe && mem_dq_oe, "R4 early write setup",
                        {p_we, p_dqoe, mem_dq_oe}, 3'b011);
                    old = mdl_mem.exists(key) ? mdl_mem[key] : 16'h0;
                    mdl_mem[key] = (old & ~lane_mask(m_lanes)) |
                                   (mem_dq_out & lane_mask(m_lanes));
                end
                rd_q = mdl_mem.exists(key) ? mdl_mem[key] : 16'h0;
            end
            if (fl) l_low = 1; else if (!mem_lcas_n) l_low++;
            if (fu) u_low = 1; else if (!mem_ucas_n) u_low++;
            if (!p_l && mem_lcas_n) chk(l_low == P_CAS, "R9 lcas width", l_low, P_CAS);
            if (!p_u && mem_ucas_n) chk(u_low == P_CAS, "R9 ucas width", u_low, P_CAS);
            p_ras = mem_ras_n; p_l = mem_lcas_n; p_u = mem_ucas_n;
            p_we = mem_we_n; p_dqoe = mem_dq_oe;
        end
    end

    assign mem_dq_in = (!mem_ras_n && !mem_oe_n && mem_we_n) ?
                       (rd_q & lane_mask(m_lanes)) : 16'h0;

    // ---------------- scoreboard ----------------
    logic [15:0] shadow [int];
    logic [15:0] exp_q [$];

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected response", rsp_rdata, 0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk(rsp_rdata == e, "R5 R3 read data", rsp_rdata, e);
            end
        end
    end

    task automatic issue(input bit wr, input logic [17:0] a, input logic [15:0] d,
                         input logic [1:0] be);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        chk(!req_ready, "R10 ready low during access", req_ready, 0);
        if (wr) begin
            logic [15:0] old;
            old = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
            shadow[int'(a)] = (old & ~lane_mask(be)) | (d & lane_mask(be));
        end else begin
            logic [15:0] s;
            s = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
            exp_q.push_back(s & lane_mask(be));
        end
    endtask

    task automatic wait_ready();
        do @(negedge clk); while (!req_ready);
    endtask

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            chk(1'b0, "watchdog", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int f0;
        repeat (4) @(negedge clk);
        chk(mem_ras_n && mem_lcas_n && mem_ucas_n && !mem_dq_oe && !rsp_valid,
            "R1 reset state", {mem_ras_n, mem_lcas_n, mem_ucas_n, mem_dq_oe, rsp_valid},
            5'b11100);
        rst_n = 1;
        @(negedge clk);
        chk(!req_ready && mem_ras_n, "R1 not ready during initial precharge",
            {req_ready, mem_ras_n}, 2'b01);

        // word write then word read, row 5 col 10
        issue(1, {9'd5, 9'd10}, 16'h1234, 2'b11);
        wait_ready();
        chk(m_row == 9'd5 && m_col == 9'd10, "R2 row/col split",
            {m_row, m_col}, {9'd5, 9'd10});
        issue(0, {9'd5, 9'd10}, 16'h0, 2'b11);
        wait_ready();

        // byte lanes
        issue(1, {9'd5, 9'd10}, 16'h55AB, 2'b01);
        wait_ready();
        chk(m_lanes == 2'b01, "R3 only low strobe", m_lanes, 2'b01);
        issue(0, {9'd5, 9'd10}, 16'h0, 2'b11);
        issue(1, {9'd5, 9'd10}, 16'hCD77, 2'b10);
        wait_ready();
        chk(m_lanes == 2'b10, "R3 only high strobe", m_lanes, 2'b10);
        issue(0, {9'd5, 9'd10}, 16'h0, 2'b01);
        issue(0, {9'd5, 9'd10}, 16'h0, 2'b10);
        issue(0, {9'd5, 9'd10}, 16'h0, 2'b11);
        wait_ready();

        // page hit: same row, another column
        f0 = ras_falls;
        issue(1, {9'd5, 9'd11}, 16'hBEEF, 2'b11);
        issue(0, {9'd5, 9'd11}, 16'h0, 2'b11);
        wait_ready();
        chk(ras_falls == f0, "R6 no row strobe on page hit", ras_falls, f0);

        // page miss
        issue(1, {9'd300, 9'd511}, 16'hA5C3, 2'b11);
        wait_ready();
        chk(ras_falls == f0 + 1, "R7 row reopened on miss", ras_falls, f0 + 1);
        chk(m_row == 9'd300 && m_col == 9'd511, "R2 row/col split miss",
            {m_row, m_col}, {9'd300, 9'd511});

        // refresh closes the row
        @(negedge clk);
        refresh_req = 1;
        repeat (P_RP + 2) @(negedge clk);
        chk(mem_ras_n && !req_ready, "R8 row closed under refresh",
            {mem_ras_n, req_ready}, 2'b10);
        refresh_req = 0;
        f0 = ras_falls;
        issue(0, {9'd300, 9'd511}, 16'h0, 2'b11);
        wait_ready();
        chk(ras_falls == f0 + 1, "R8 row reopened after refresh", ras_falls, f0 + 1);

        // mixed pattern across rows and lanes
        for (int i = 0; i < 24; i++) begin
            logic [17:0] a;
            a = {9'(i % 3 * 97), 9'(i * 37)};
            issue(1, a, 16'(i * 16'h1357 ^ 16'h8421), 2'(i % 3 + 1));
        end
        for (int i = 0; i < 24; i++) begin
            logic [17:0] a;
            a = {9'(i % 3 * 97), 9'(i * 37)};
            issue(0, a, 16'h0, 2'(3 - i % 3));
        end
        wait_ready();
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all responses seen", exp_q.size(), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule